// File: doc/BRIEF.md
# Long Conditional Branch Unit

This block resolves a two-byte long conditional branch. It receives the escape byte, the second opcode byte, a signed 16-bit displacement, the address of the branch instruction and the four condition flags. It decides whether the opcode is a long branch and whether the branch is taken, and it works out the following program counter. A small sequencer then steps through the bus access slots of the instruction, one per clock. A taken branch occupies more slots than one that falls through.

A one-cycle `start` pulse loads all inputs and the resolved result into registers. The results stay on the outputs until the next accepted start. `done` is high during the final access slot of the sequence. `acc_fetch` marks each slot that is a program fetch; every other slot is a free cycle. The flags come back on `ccr_out` exactly as they were sampled, because a branch never changes a flag.

Top module: `lbr_unit`

## Requirements
- R1: The opcode is legal (`legal`=1) exactly when `prefix` is 0x18 and the upper nibble of `opcode` is 0x2. The lower nibble of `opcode` then selects the condition.
- R2: Flags are `ccr_in[3]`=N, `[2]`=Z, `[1]`=V and `[0]`=C. The branch is taken when the condition holds. The even nibbles are: 0 always, 2 when C|Z=0, 4 when C=0, 6 when Z=0, 8 when V=0, A when N=0, C when N^V=0, and E when Z|(N^V)=0. Each odd nibble is the inverse of the even nibble below it, so 1 means never, 3 means C|Z=1, and so on.
- R3: For a taken branch, `next_pc` equals `pc_in` + 4 + the sign-extended `disp`, modulo 2^16.
- R4: For a legal branch that is not taken, `next_pc` equals `pc_in` + 4, modulo 2^16.
- R5: For an illegal opcode, `taken`=0 and `next_pc`=`pc_in`. The sequence then lasts one slot with no fetch, and `cycles`=1.
- R6: A taken branch lasts 4 slots and a not-taken branch lasts 3. `done` is high only in the last slot, and `cycles` reports the slot count.
- R7: A taken branch performs the slots in the order free, fetch, fetch, fetch. A not-taken branch performs them in the order free, fetch, free. `acc_fetch` is high only during fetch slots.
- R8: `ccr_out` equals the `ccr_in` value that was sampled at the accepted start.
- R9: A `start` that arrives while a sequence is running is ignored, and the results of the running branch are kept.
- R10: `rst` is synchronous and active high. It returns the block to idle with `busy`, `done`, `acc_fetch`, `taken`, `legal`, `next_pc`, `cycles` and `ccr_out` all at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that loads the inputs and begins a sequence |
| prefix | input | 8 | Escape byte |
| opcode | input | 8 | Second opcode byte |
| disp | input | 16 | Signed displacement |
| pc_in | input | 16 | Address of the branch instruction |
| ccr_in | input | 4 | Flags {N,Z,V,C} |
| taken | output | 1 | Branch taken |
| legal | output | 1 | Opcode is a long branch |
| next_pc | output | 16 | Resolved following address |
| cycles | output | 3 | Number of access slots of the sequence |
| busy | output | 1 | Sequence running |
| done | output | 1 | Last slot of the sequence |
| acc_fetch | output | 1 | Current slot is a program fetch |
| ccr_out | output | 4 | Flags returned unchanged |

## Verification
Each of the sixteen condition nibbles is run against all sixteen flag patterns. This shows whether each predicate uses the correct flags with the correct sense, and it separates a nibble from its inverse. The displacement extremes 0x7FFF and 0x8000 are combined with addresses near both ends of the space, which exposes faulty sign extension, a wrong instruction length and a missing wrap. Random escape and opcode bytes, both inside and outside the branch group, show the difference between the illegal path and the two legal paths in the address, the slot count and the fetch pattern. Starts issued in the middle of a sequence show that the running results are left alone.

// File: rtl/lbr_pkg.sv
package lbr_pkg;
  localparam int CCR_W  = 4;
  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_V = 1;
  localparam int FLAG_C = 0;

  typedef enum logic [0:0] {SEQ_IDLE = 1'b0, SEQ_RUN = 1'b1} seq_state_e;

  // Predicate of an even condition nibble (true sense); the odd one inverts it.
  function automatic logic base_pred(input logic [2:0] pair, input logic [CCR_W-1:0] ccr);
    logic n, z, v, c;
    n = ccr[FLAG_N];
    z = ccr[FLAG_Z];
    v = ccr[FLAG_V];
    c = ccr[FLAG_C];
    case (pair)
      3'd0:    base_pred = 1'b1;
      3'd1:    base_pred = ~(c | z);
      3'd2:    base_pred = ~c;
      3'd3:    base_pred = ~z;
      3'd4:    base_pred = ~v;
      3'd5:    base_pred = ~n;
      3'd6:    base_pred = ~(n ^ v);
      default: base_pred = ~(z | (n ^ v));
    endcase
  endfunction
endpackage

// File: rtl/lbr_decode.sv
module lbr_decode #(
  parameter int              BYTE_W      = 8,
  parameter logic [7:0]      PREFIX_CODE = 8'h18,
  parameter logic [3:0]      GROUP_CODE  = 4'h2
) (
  input  logic [BYTE_W-1:0] prefix,
  input  logic [BYTE_W-1:0] opcode,
  output logic              legal_now,
  output logic [3:0]        cond_sel
);
  localparam int HI_LSB = BYTE_W - 4;

  logic prefix_hit;
  logic group_hit;

  assign prefix_hit = (prefix == BYTE_W'(PREFIX_CODE));
  assign group_hit  = (opcode[BYTE_W-1:HI_LSB] == GROUP_CODE);
  assign legal_now  = prefix_hit & group_hit;
  assign cond_sel   = opcode[3:0];
endmodule

// File: rtl/lbr_cond.sv
module lbr_cond
  import lbr_pkg::*;
(
  input  logic [CCR_W-1:0] ccr,
  input  logic [3:0]       cond_sel,
  input  logic             legal_now,
  output logic             taken_now
);
  logic [15:0] pred_vec;

  for (genvar i = 0; i < 16; i++) begin : g_pred
    localparam logic [3:0] IDX = 4'(i);
    assign pred_vec[i] = base_pred(IDX[3:1], ccr) ^ IDX[0];
  end

  assign taken_now = legal_now & pred_vec[cond_sel];
endmodule

// File: rtl/lbr_target.sv
module lbr_target #(
  parameter int PC_W     = 16,
  parameter int DISP_W   = 16,
  parameter int INSN_LEN = 4
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [DISP_W-1:0] disp,
  input  logic              legal_now,
  input  logic              taken_now,
  output logic [PC_W-1:0]   target_now
);
  function automatic logic [PC_W-1:0] fall_through(input logic [PC_W-1:0] a);
    fall_through = a + PC_W'(INSN_LEN);
  endfunction

  function automatic logic [PC_W-1:0] rel_target(input logic [PC_W-1:0] a,
                                                 input logic [DISP_W-1:0] d);
    logic signed [DISP_W-1:0] sd;
    logic [PC_W-1:0]          ext;
    sd  = d;
    ext = PC_W'(sd);
    rel_target = fall_through(a) + ext;
  endfunction

  always_comb begin
    if (!legal_now)     target_now = pc;
    else if (taken_now) target_now = rel_target(pc, disp);
    else                target_now = fall_through(pc);
  end
endmodule

// File: rtl/lbr_seq.sv
module lbr_seq
  import lbr_pkg::*;
#(
  parameter int CNT_W          = 3,
  parameter int TAKEN_CYC      = 4,
  parameter int NOTTAKEN_CYC   = 3,
  parameter int ILLEGAL_CYC    = 1,
  parameter int TAKEN_FIRST    = 2,
  parameter int TAKEN_LAST     = 4,
  parameter int NOTTAKEN_FIRST = 2,
  parameter int NOTTAKEN_LAST  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             legal_now,
  input  logic             taken_now,
  output logic             start_accept,
  output logic             busy,
  output logic             done,
  output logic             acc_fetch,
  output logic [CNT_W-1:0] cycles
);
  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] total_q;
  logic [CNT_W-1:0] first_q;
  logic [CNT_W-1:0] last_q;
  logic [CNT_W-1:0] total_sel, first_sel, last_sel;

  always_comb begin
    if (!legal_now) begin
      total_sel = CNT_W'(ILLEGAL_CYC);
      first_sel = CNT_W'(1);
      last_sel  = CNT_W'(0);
    end else if (taken_now) begin
      total_sel = CNT_W'(TAKEN_CYC);
      first_sel = CNT_W'(TAKEN_FIRST);
      last_sel  = CNT_W'(TAKEN_LAST);
    end else begin
      total_sel = CNT_W'(NOTTAKEN_CYC);
      first_sel = CNT_W'(NOTTAKEN_FIRST);
      last_sel  = CNT_W'(NOTTAKEN_LAST);
    end
  end

  assign busy         = (state_q == SEQ_RUN);
  assign start_accept = start & (state_q == SEQ_IDLE);
  assign done         = busy & (cnt_q == total_q);
  assign acc_fetch    = busy & (cnt_q >= first_q) & (cnt_q <= last_q);
  assign cycles       = total_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      total_q <= '0;
      first_q <= '0;
      last_q  <= '0;
    end else if (start_accept) begin
      state_q <= SEQ_RUN;
      cnt_q   <= CNT_W'(1);
      total_q <= total_sel;
      first_q <= first_sel;
      last_q  <= last_sel;
    end else if (busy) begin
      if (cnt_q == total_q) state_q <= SEQ_IDLE;
      else                  cnt_q   <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/lbr_unit.sv
module lbr_unit
  import lbr_pkg::*;
#(
  parameter int         PC_W        = 16,
  parameter int         DISP_W      = 16,
  parameter int         BYTE_W      = 8,
  parameter logic [7:0] PREFIX_CODE = 8'h18,
  parameter logic [3:0] GROUP_CODE  = 4'h2,
  parameter int         INSN_LEN    = 4,
  parameter int         CNT_W       = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [BYTE_W-1:0] prefix,
  input  logic [BYTE_W-1:0] opcode,
  input  logic [DISP_W-1:0] disp,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [3:0]        ccr_in,
  output logic              taken,
  output logic              legal,
  output logic [PC_W-1:0]   next_pc,
  output logic [CNT_W-1:0]  cycles,
  output logic              busy,
  output logic              done,
  output logic              acc_fetch,
  output logic [3:0]        ccr_out
);
  logic            legal_now;
  logic [3:0]      cond_sel;
  logic            taken_now;
  logic [PC_W-1:0] target_now;
  logic            start_accept;

  lbr_decode #(
    .BYTE_W(BYTE_W), .PREFIX_CODE(PREFIX_CODE), .GROUP_CODE(GROUP_CODE)
  ) u_decode (
    .prefix(prefix), .opcode(opcode), .legal_now(legal_now), .cond_sel(cond_sel)
  );

  lbr_cond u_cond (
    .ccr(ccr_in), .cond_sel(cond_sel), .legal_now(legal_now), .taken_now(taken_now)
  );

  lbr_target #(
    .PC_W(PC_W), .DISP_W(DISP_W), .INSN_LEN(INSN_LEN)
  ) u_target (
    .pc(pc_in), .disp(disp), .legal_now(legal_now), .taken_now(taken_now),
    .target_now(target_now)
  );

  lbr_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .legal_now(legal_now), .taken_now(taken_now),
    .start_accept(start_accept), .busy(busy), .done(done), .acc_fetch(acc_fetch),
    .cycles(cycles)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      taken   <= 1'b0;
      legal   <= 1'b0;
      next_pc <= '0;
      ccr_out <= '0;
    end else if (start_accept) begin
      taken   <= taken_now;
      legal   <= legal_now;
      next_pc <= target_now;
      ccr_out <= ccr_in;
    end
  end
endmodule

// File: rtl/lbr_chk.sv
module lbr_chk #(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             start_accept,
  input logic             legal_now,
  input logic [3:0]       cond_sel,
  input logic             busy,
  input logic             done,
  input logic             acc_fetch,
  input logic             legal,
  input logic             taken,
  input logic [CNT_W-1:0] cycles,
  input logic [3:0]       ccr_in,
  input logic [3:0]       ccr_out
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);                                                  // R6
  AST_LEGAL_SLOTS: assert property (@(posedge clk) disable iff (rst)
    (done && legal) |-> (cycles == (taken ? CNT_W'(4) : CNT_W'(3)))); // R6
  AST_ILLEGAL_SHORT: assert property (@(posedge clk) disable iff (rst)
    (done && !legal) |-> (cycles == CNT_W'(1) && !taken && !acc_fetch)); // R5
  AST_NEVER_COND: assert property (@(posedge clk) disable iff (rst)
    (start_accept && legal_now && cond_sel == 4'h1) |=> !taken);      // R2
  AST_ALWAYS_COND: assert property (@(posedge clk) disable iff (rst)
    (start_accept && legal_now && cond_sel == 4'h0) |=> taken);       // R2
  AST_FLAGS_KEPT: assert property (@(posedge clk) disable iff (rst)
    start_accept |=> (ccr_out == $past(ccr_in)));                      // R8
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(ccr_out) && $stable(cycles) && $stable(taken))); // R9
  AST_FETCH_IN_SEQ: assert property (@(posedge clk) disable iff (rst)
    acc_fetch |-> busy);                                               // R7
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!busy && !done));                                         // R10
endmodule

bind lbr_unit lbr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .start_accept(start_accept),
  .legal_now(legal_now), .cond_sel(cond_sel), .busy(busy), .done(done),
  .acc_fetch(acc_fetch), .legal(legal), .taken(taken), .cycles(cycles),
  .ccr_in(ccr_in), .ccr_out(ccr_out)
);

// File: tb/lbr_unit_tb.sv
module lbr_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  prefix = '0;
  logic [7:0]  opcode = '0;
  logic [15:0] disp = '0;
  logic [15:0] pc_in = '0;
  logic [3:0]  ccr_in = '0;
  logic        taken, legal, busy, done, acc_fetch;
  logic [15:0] next_pc;
  logic [2:0]  cycles;
  logic [3:0]  ccr_out;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lbr_unit u_dut (
    .clk(clk), .rst(rst), .start(start), .prefix(prefix), .opcode(opcode),
    .disp(disp), .pc_in(pc_in), .ccr_in(ccr_in), .taken(taken), .legal(legal),
    .next_pc(next_pc), .cycles(cycles), .busy(busy), .done(done),
    .acc_fetch(acc_fetch), .ccr_out(ccr_out)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Condition truth written directly from the flag letters
  function automatic bit exp_cond(input logic [3:0] nib, input logic [3:0] f);
    bit n, z, v, c;
    n = f[3]; z = f[2]; v = f[1]; c = f[0];
    case (nib)
      4'h0: return 1;             4'h1: return 0;
      4'h2: return (c | z) == 0;  4'h3: return (c | z) == 1;
      4'h4: return c == 0;        4'h5: return c == 1;
      4'h6: return z == 0;        4'h7: return z == 1;
      4'h8: return v == 0;        4'h9: return v == 1;
      4'hA: return n == 0;        4'hB: return n == 1;
      4'hC: return (n ^ v) == 0;  4'hD: return (n ^ v) == 1;
      4'hE: return (z | (n ^ v)) == 0;
      default: return (z | (n ^ v)) == 1;
    endcase
  endfunction

  function automatic logic [15:0] exp_pc(input bit lg, input bit tk,
                                         input logic [15:0] pc, input logic [15:0] d);
    logic [31:0] wide;
    if (!lg) return pc;
    wide = {16'h0, pc} + 32'd4;
    if (tk) wide = wide + {{16{d[15]}}, d};
    return wide[15:0];
  endfunction

  task automatic run_one(input logic [7:0] pf, input logic [7:0] op, input logic [15:0] d,
                         input logic [15:0] pc, input logic [3:0] f, input bit poke);
    bit          lg, tk;
    int          n;
    logic [7:0]  pat;
    int          exp_n;
    logic [7:0]  exp_pat;
    lg = (pf == 8'h18) && (op[7:4] == 4'h2);
    tk = lg && exp_cond(op[3:0], f);
    exp_n   = !lg ? 1 : (tk ? 4 : 3);
    exp_pat = !lg ? 8'h00 : (tk ? 8'h0E : 8'h02);
    @(negedge clk);
    prefix = pf; opcode = op; disp = d; pc_in = pc; ccr_in = f; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R9: a fresh start with other operands during the sequence
      prefix = 8'h18; opcode = {4'h2, ~op[3:0]}; disp = ~d; pc_in = ~pc; ccr_in = ~f;
      start = 1'b1;
    end
    n = 0; pat = '0;
    forever begin
      n++;
      pat[n-1] = acc_fetch;
      if (done || n >= 8) break;
      @(negedge clk);
      start = 1'b0;
    end
    start = 1'b0;
    chk(legal == lg, "R1 legal", 32'(legal), 32'(lg));
    chk(taken == tk, "R2 taken", 32'(taken), 32'(tk));
    chk(next_pc == exp_pc(lg, tk, pc, d), lg ? (tk ? "R3 target" : "R4 fallthrough") : "R5 pc held",
        32'(next_pc), 32'(exp_pc(lg, tk, pc, d)));
    chk(n == exp_n, "R6 slot count", 32'(n), 32'(exp_n));
    chk(32'(cycles) == 32'(exp_n), "R6 cycles out", 32'(cycles), 32'(exp_n));
    chk(pat == exp_pat, "R7 fetch pattern", 32'(pat), 32'(exp_pat));
    chk(ccr_out == f, "R8 flags kept", 32'(ccr_out), 32'(f));
    if (poke) chk(1'b1 && next_pc == exp_pc(lg, tk, pc, d), "R9 start ignored",
                  32'(next_pc), 32'(exp_pc(lg, tk, pc, d)));
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h1BAD5EED);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    chk(!busy && !done && !acc_fetch, "R10 idle", {29'h0, busy, done, acc_fetch}, 32'h0);
    chk(!taken && !legal && next_pc == 0 && cycles == 0 && ccr_out == 0, "R10 outputs",
        {taken, legal, cycles, ccr_out, next_pc}, 32'h0);
    rst = 1'b0;

    // R2 every condition against every flag pattern
    for (int nib = 0; nib < 16; nib++)
      for (int fl = 0; fl < 16; fl++)
        run_one(8'h18, {4'h2, 4'(nib)}, 16'h0123, 16'h4000, 4'(fl), 1'b0);

    // R3 displacement extremes and wrap
    run_one(8'h18, 8'h20, 16'h7FFF, 16'h0000, 4'h0, 1'b0);
    run_one(8'h18, 8'h20, 16'h8000, 16'h0000, 4'h0, 1'b0);
    run_one(8'h18, 8'h20, 16'h7FFF, 16'hFFF0, 4'h5, 1'b0);
    run_one(8'h18, 8'h20, 16'h8000, 16'h8010, 4'hA, 1'b0);
    run_one(8'h18, 8'h20, 16'hFFFC, 16'h1234, 4'h0, 1'b0);
    // R4 fall-through wrap
    run_one(8'h18, 8'h21, 16'h7FFF, 16'hFFFE, 4'h3, 1'b0);
    // R1 R5 illegal boundaries
    run_one(8'h18, 8'h1F, 16'h0010, 16'h2222, 4'h0, 1'b0);
    run_one(8'h18, 8'h30, 16'h0010, 16'h3333, 4'h0, 1'b0);
    run_one(8'h19, 8'h20, 16'h0010, 16'h4444, 4'h0, 1'b0);
    // R9 start during a running sequence
    run_one(8'h18, 8'h27, 16'h0100, 16'h5000, 4'h4, 1'b1);
    run_one(8'h18, 8'h26, 16'h0100, 16'h5000, 4'h4, 1'b1);

    // Random mix, biased toward the branch group
    for (int k = 0; k < 300; k++) begin
      logic [7:0] pf, op;
      pf = ($urandom % 4 == 0) ? 8'($urandom) : 8'h18;
      op = ($urandom % 4 == 0) ? 8'($urandom) : {4'h2, 4'($urandom)};
      run_one(pf, op, 16'($urandom), 16'($urandom), 4'($urandom), ($urandom % 5) == 0);
    end

    // R10 reset in the middle of a sequence
    @(negedge clk);
    prefix = 8'h18; opcode = 8'h20; start = 1'b1;
    @(negedge clk);
    start = 1'b0; rst = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !taken && cycles == 0, "R10 reset mid run",
        {28'h0, busy, done, taken, 1'b0}, 32'h0);
    rst = 1'b0;

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule